// File: doc/BRIEF.md
# Always-On Reset Conditioner with Scan Override

This block takes an asynchronous, active-low power-on input and turns it into a clean reset for an always-on clock domain. The input must stay high for a fixed number of always-on clock edges before the reset is released. Any low level on the input asserts the reset again at once and starts the count over. From that stretched reset the block derives a lifecycle reset and a system reset for each power domain. Each derived reset can also be forced by an active-high request for its own domain. Derived resets assert asynchronously and release through a two-flop synchronizer on the always-on clock.

A 4-bit encoded scan-mode input selects test mode only when it holds exactly the code `4'b0110`. Every other code, including the nominal off code `4'b1001`, counts as functional mode. In test mode the power-on input is ignored and a dedicated scan reset pin alone drives the always-on reset and, through it, every derived reset.

Top module: `aon_reset_conditioner`

## Requirements
- R1: Test mode is active only when `scan_mode_i` equals `4'b0110`. Any other code, such as `4'b1001` or `4'b0111`, leaves the block in functional mode, where the power-on input governs.
- R2: In test mode, `por_ni` has no effect on any output.
- R3: In test mode, `aon_rst_no` follows `scan_rst_ni` combinationally, and it is high whenever `scan_rst_ni` is high.
- R4: In functional mode, a low `por_ni` drives `aon_rst_no` and every derived reset low without waiting for a clock edge.
- R5: After `por_ni` rises in functional mode, `aon_rst_no` stays low through the first 31 rising clock edges and goes high on the 32nd (`MIN_CYC` = 32).
- R6: A low pulse on `por_ni` during the stable count restarts it, so a full 32 further high edges are needed before release.
- R7: `lc_rst_no[d]` is low, asynchronously, whenever `aon_rst_no` is low or `lc_req_i[d]` is high.
- R8: `sys_rst_no[d]` is low, asynchronously, whenever `aon_rst_no` is low or `sys_req_i[d]` is high.
- R9: A derived reset goes high on the second rising clock edge after its cause clears (that is, after `aon_rst_no` rises with the request low, or after the request falls).
- R10: A request for one domain, or for one reset kind, leaves the other domain's resets and the other kind unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| scan_mode_i | input | 4 | Encoded test-mode select; `4'b0110` means test mode |
| scan_rst_ni | input | 1 | Test-mode reset, active low |
| lc_req_i | input | NUM_DOM | Lifecycle reset request per domain, active high |
| sys_req_i | input | NUM_DOM | System reset request per domain, active high |
| aon_rst_no | output | 1 | Stretched always-on reset, active low |
| lc_rst_no | output | NUM_DOM | Lifecycle reset per domain, active low |
| sys_rst_no | output | NUM_DOM | System reset per domain, active low |

## Verification
The results fall into three timing classes:
- Assertion paths, and every effect of the scan override, act within the same cycle. The bench samples these 1 ns after the stimulus is driven on a falling edge.
- `aon_rst_no` rises on the 32nd rising edge after `por_ni` rises. The bench checks that it is still low after 31 edges and high after 32.
- A derived reset releases on the second edge after its cause clears. The bench checks it low after one edge and high after two.

All stimulus is applied on falling clock edges and all samples are taken on falling edges, so every count of rising edges is exact.

// File: rtl/porst_pkg.sv
package porst_pkg;

    localparam int unsigned SCAN_W = 4;
    localparam logic [SCAN_W-1:0] SCAN_ON  = 4'b0110;
    localparam logic [SCAN_W-1:0] SCAN_OFF = 4'b1001;

    // Strict decode: only the exact on code selects test mode.
    function automatic logic scan_is_on(input logic [SCAN_W-1:0] code);
        return code == SCAN_ON;
    endfunction

endpackage

// File: rtl/por_stretch.sv
module por_stretch #(
    parameter int unsigned MIN_CYC = 32
) (
    input  logic clk_i,
    input  logic por_ni,
    output logic rel_o
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rel;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.rel) begin
            if (st_q.cnt == CW'(MIN_CYC - 1)) begin
                st_d.cnt = CW'(MIN_CYC);
                st_d.rel = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rel_o = st_q.rel;

endmodule

// File: rtl/rst_sync2.sv
module rst_sync2 #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    output logic rst_no
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign rst_no = sh_q[STAGES-1];

endmodule

// File: rtl/aon_reset_conditioner.sv
module aon_reset_conditioner #(
    parameter int unsigned NUM_DOM     = 2,
    parameter int unsigned MIN_CYC     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk_i,
    input  logic                       por_ni,
    input  logic [porst_pkg::SCAN_W-1:0] scan_mode_i,
    input  logic                       scan_rst_ni,
    input  logic [NUM_DOM-1:0]         lc_req_i,
    input  logic [NUM_DOM-1:0]         sys_req_i,
    output logic                       aon_rst_no,
    output logic [NUM_DOM-1:0]         lc_rst_no,
    output logic [NUM_DOM-1:0]         sys_rst_no
);
    logic scan_act;
    logic gated_por_n;
    logic stretched_n;

    always_comb begin
        scan_act    = porst_pkg::scan_is_on(scan_mode_i);
        gated_por_n = por_ni & ~scan_act;
        aon_rst_no  = scan_act ? scan_rst_ni : stretched_n;
    end

    por_stretch #(.MIN_CYC(MIN_CYC)) u_stretch (
        .clk_i  (clk_i),
        .por_ni (gated_por_n),
        .rel_o  (stretched_n)
    );

    logic [NUM_DOM-1:0] lc_raw_n, sys_raw_n;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign lc_raw_n[d]  = aon_rst_no & ~lc_req_i[d];
        assign sys_raw_n[d] = aon_rst_no & ~sys_req_i[d];

        rst_sync2 #(.STAGES(SYNC_STAGES)) u_lc_sync (
            .clk_i   (clk_i),
            .arst_ni (lc_raw_n[d]),
            .rst_no  (lc_rst_no[d])
        );

        rst_sync2 #(.STAGES(SYNC_STAGES)) u_sys_sync (
            .clk_i   (clk_i),
            .arst_ni (sys_raw_n[d]),
            .rst_no  (sys_rst_no[d])
        );
    end

endmodule

// File: rtl/porst_checker.sv
module porst_checker #(
    parameter int unsigned NUM_DOM = 2,
    parameter int unsigned MIN_CYC = 32
) (
    input logic                         clk_i,
    input logic                         por_ni,
    input logic [porst_pkg::SCAN_W-1:0] scan_mode_i,
    input logic                         scan_rst_ni,
    input logic [NUM_DOM-1:0]           lc_req_i,
    input logic [NUM_DOM-1:0]           sys_req_i,
    input logic                         aon_rst_no,
    input logic [NUM_DOM-1:0]           lc_rst_no,
    input logic [NUM_DOM-1:0]           sys_rst_no
);
    localparam int unsigned HW = $clog2(MIN_CYC + 2);

    logic [1:0]    age_q = '0;
    logic          armed;
    logic [HW-1:0] hi_cnt_q = '0;
    logic          in_scan;

    assign in_scan = (scan_mode_i == 4'b0110);
    assign armed   = (age_q == 2'd2);

    always_ff @(posedge clk_i) begin
        if (!armed) age_q <= age_q + 1'b1;
        if (!por_ni || in_scan) hi_cnt_q <= '0;
        else if (hi_cnt_q != HW'(MIN_CYC + 1)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    // R3: scan reset high in test mode releases the always-on reset
    a_r3_scan_release: assert property (@(posedge clk_i) disable iff (!armed)
        in_scan && scan_rst_ni |-> aon_rst_no);

    // R4: power-on low in functional mode holds reset
    a_r4_por_low_holds: assert property (@(posedge clk_i) disable iff (!armed)
        !in_scan && !por_ni |-> !aon_rst_no);

    // R5: no release before the stable count completes
    a_r5_no_early_release: assert property (@(posedge clk_i) disable iff (!armed)
        !in_scan && aon_rst_no && !$past(aon_rst_no) |-> hi_cnt_q >= HW'(MIN_CYC));

    // R5: release no later than the edge after the count completes
    a_r5_bounded_release: assert property (@(posedge clk_i) disable iff (!armed)
        !in_scan && por_ni && hi_cnt_q >= HW'(MIN_CYC) |-> aon_rst_no);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
        // R7
        a_r7_lc_held: assert property (@(posedge clk_i) disable iff (!armed)
            !aon_rst_no || lc_req_i[d] |-> !lc_rst_no[d]);
        // R8
        a_r8_sys_held: assert property (@(posedge clk_i) disable iff (!armed)
            !aon_rst_no || sys_req_i[d] |-> !sys_rst_no[d]);
        // R9
        a_r9_lc_release_sync: assert property (@(posedge clk_i) disable iff (!armed)
            $rose(lc_rst_no[d]) |-> $past(aon_rst_no && !lc_req_i[d]));
        a_r9_sys_release_sync: assert property (@(posedge clk_i) disable iff (!armed)
            $rose(sys_rst_no[d]) |-> $past(aon_rst_no && !sys_req_i[d]));
    end

endmodule

bind aon_reset_conditioner porst_checker #(
    .NUM_DOM (NUM_DOM),
    .MIN_CYC (MIN_CYC)
) u_porst_chk (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .scan_mode_i (scan_mode_i),
    .scan_rst_ni (scan_rst_ni),
    .lc_req_i    (lc_req_i),
    .sys_req_i   (sys_req_i),
    .aon_rst_no  (aon_rst_no),
    .lc_rst_no   (lc_rst_no),
    .sys_rst_no  (sys_rst_no)
);

// File: tb/tb_aon_reset_conditioner.sv
`timescale 1ns/1ps
module tb_aon_reset_conditioner;
    localparam int ND = 2;

    logic          clk_i = 1'b0;
    logic          por_ni = 1'b0;
    logic [3:0]    scan_mode_i = 4'b1001;
    logic          scan_rst_ni = 1'b0;
    logic [ND-1:0] lc_req_i = '0;
    logic [ND-1:0] sys_req_i = '0;
    logic          aon_rst_no;
    logic [ND-1:0] lc_rst_no, sys_rst_no;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk_i = ~clk_i;

    aon_reset_conditioner dut (
        .clk_i(clk_i), .por_ni(por_ni), .scan_mode_i(scan_mode_i),
        .scan_rst_ni(scan_rst_ni), .lc_req_i(lc_req_i), .sys_req_i(sys_req_i),
        .aon_rst_no(aon_rst_no), .lc_rst_no(lc_rst_no), .sys_rst_no(sys_rst_no)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic t_reset_state();
        tick(3);
        chk("R4 reset aon", {7'd0, aon_rst_no}, 8'd0);
        chk("R7 reset lc", {6'd0, lc_rst_no}, 8'd0);
        chk("R8 reset sys", {6'd0, sys_rst_no}, 8'd0);
    endtask

    task automatic t_release();
        por_ni = 1'b1;
        tick(31);
        chk("R5 aon low after 31 edges", {7'd0, aon_rst_no}, 8'd0);
        tick(1);
        chk("R5 aon high after 32 edges", {7'd0, aon_rst_no}, 8'd1);
        chk("R7 lc still low", {6'd0, lc_rst_no}, 8'd0);
        tick(1);
        chk("R9 lc low one edge after", {6'd0, lc_rst_no}, 8'd0);
        chk("R9 sys low one edge after", {6'd0, sys_rst_no}, 8'd0);
        tick(1);
        chk("R9 lc high two edges after", {6'd0, lc_rst_no}, 8'd3);
        chk("R9 sys high two edges after", {6'd0, sys_rst_no}, 8'd3);
    endtask

    task automatic t_requests();
        lc_req_i = 2'b01;
        #1;
        chk("R7 lc0 async assert", {6'd0, lc_rst_no}, 8'd2);
        chk("R10 sys untouched by lc req", {6'd0, sys_rst_no}, 8'd3);
        tick(1);
        lc_req_i = 2'b00;
        tick(1);
        chk("R9 lc0 low one edge after req drop", {6'd0, lc_rst_no}, 8'd2);
        tick(1);
        chk("R9 lc0 high two edges after req drop", {6'd0, lc_rst_no}, 8'd3);
        sys_req_i = 2'b10;
        #1;
        chk("R8 sys1 async assert", {6'd0, sys_rst_no}, 8'd1);
        chk("R10 lc untouched by sys req", {6'd0, lc_rst_no}, 8'd3);
        tick(1);
        sys_req_i = 2'b00;
        tick(2);
        chk("R9 sys1 released", {6'd0, sys_rst_no}, 8'd3);
    endtask

    task automatic t_glitch();
        por_ni = 1'b0;
        #1;
        chk("R4 aon async assert", {7'd0, aon_rst_no}, 8'd0);
        chk("R4 lc async assert", {6'd0, lc_rst_no}, 8'd0);
        chk("R4 sys async assert", {6'd0, sys_rst_no}, 8'd0);
        tick(1);
        por_ni = 1'b1;
        tick(20);
        por_ni = 1'b0;
        tick(1);
        por_ni = 1'b1;
        tick(31);
        chk("R6 count restarted, still low", {7'd0, aon_rst_no}, 8'd0);
        tick(1);
        chk("R6 release after full count", {7'd0, aon_rst_no}, 8'd1);
        tick(2);
    endtask

    task automatic t_scan();
        scan_mode_i = 4'b0110;
        scan_rst_ni = 1'b1;
        por_ni = 1'b0;
        #1;
        chk("R2 por ignored in test mode", {7'd0, aon_rst_no}, 8'd1);
        chk("R3 scan high releases aon", {6'd0, lc_rst_no}, 8'd3);
        scan_rst_ni = 1'b0;
        #1;
        chk("R3 scan low asserts aon", {7'd0, aon_rst_no}, 8'd0);
        chk("R3 scan low asserts sys", {6'd0, sys_rst_no}, 8'd0);
        tick(1);
        scan_rst_ni = 1'b1;
        tick(2);
        chk("R9 lc release in test mode", {6'd0, lc_rst_no}, 8'd3);
        por_ni = 1'b1;
        tick(1);
        por_ni = 1'b0;
        tick(1);
        chk("R2 por toggles ignored", {7'd0, aon_rst_no}, 8'd1);
        chk("R2 lc unaffected by por", {6'd0, lc_rst_no}, 8'd3);
        scan_mode_i = 4'b0111;
        #1;
        chk("R1 near code is functional", {7'd0, aon_rst_no}, 8'd0);
        tick(1);
        scan_mode_i = 4'b1001;
        por_ni = 1'b1;
        tick(31);
        chk("R1 off code counts normally, low", {7'd0, aon_rst_no}, 8'd0);
        tick(1);
        chk("R1 off code counts normally, high", {7'd0, aon_rst_no}, 8'd1);
    endtask

    initial begin
        t_reset_state();
        t_release();
        t_requests();
        t_glitch();
        t_scan();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk_i);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule